// File: doc/BRIEF.md
# Debug Transmit Data Channel Register

This block holds a single data word that travels from the processor to an external debugger. The processor side deposits a word with a write strobe. The debugger side collects the word with a read strobe. A full flag shows that a deposited word is still waiting to be collected. Sticky status flags record two faults: a read that found nothing waiting (underrun, together with a general error flag), and a write that replaced a word nobody had collected (overrun).

Both ports may strobe in the same clock cycle. The block resolves this as if the two accesses happened one after the other, never as a mix of the two. It uses a fixed order in which the write comes first, so the read collects the word written in that same cycle. Each access updates the flags as part of the same atomic step. The debugger clears the sticky flags with a one-cycle clear pulse.

Top module: `dbg_tx_channel`

## Requirements
- R1: A write strobe without a read strobe stores `core_wdata` and sets `full` to 1 on the next clock edge.
- R2: A read strobe while `full` is 1, with no write strobe, clears `full` to 0 and returns the stored word. It leaves `underrun` and `error` unchanged.
- R3: A read strobe while `full` is 0, with no write strobe, is an underrun. It sets `underrun` and `error` to 1, leaves `full` at 0 and returns the value 0.
- R4: When write and read strobe in the same cycle, the write is taken first. The read returns the new word, `full` ends at 0 and no underrun is flagged. If `full` was 1 before that cycle, `overrun` is set.
- R5: Read data appears on `ext_rdata` in the cycle after the read strobe. It holds its value until the next read strobe.
- R6: `underrun`, `error` and `overrun` are sticky. They stay set until `clr_sticky` is pulsed, and that pulse clears all three. If a new fault occurs in the same cycle as the clear, the flag for that fault ends at 1.
- R7: A write while `full` is 1 replaces the stored word, sets `overrun` to 1 and keeps `full` at 1. A later read returns the newest word.
- R8: After reset, all flags, the stored word and `ext_rdata` are 0.
- R9: In a cycle with neither strobe, `full` and the stored word keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_wr | input | 1 | Processor-side write strobe |
| core_wdata | input | WIDTH | Word to deposit |
| ext_rd | input | 1 | Debugger-side read strobe |
| ext_rdata | output | WIDTH | Word returned by the last read |
| clr_sticky | input | 1 | Clears the sticky status flags |
| full | output | 1 | A deposited word is waiting to be collected |
| underrun | output | 1 | Sticky: a read found no word waiting |
| error | output | 1 | Sticky: general error, raised by an underrun |
| overrun | output | 1 | Sticky: a waiting word was replaced |

## Verification
The hardest case to reach is a collision that lands on a channel that is already full. In that cycle the overrun must be recorded even though `full` ends at 0 and the read returns the new word. The stimulus first loads a word, then strobes write and read together in one cycle. A second hard case is a clear pulse in the same cycle as a fresh underrun. It is reached by raising the underrun, then strobing `clr_sticky` and `ext_rd` together while the channel is empty.

// File: rtl/dbg_tx_channel.sv
module dbg_tx_channel #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_wr,
  input  logic [WIDTH-1:0] core_wdata,
  input  logic             ext_rd,
  output logic [WIDTH-1:0] ext_rdata,
  input  logic             clr_sticky,
  output logic             full,
  output logic             underrun,
  output logic             error,
  output logic             overrun
);

  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] rdata_q;
  logic             full_q, under_q, err_q, ovr_q;

  wire collide   = core_wr & ext_rd;
  wire under_evt = ext_rd & ~core_wr & ~full_q;
  wire ovr_evt   = core_wr & full_q;

  wire [WIDTH-1:0] read_val = collide ? core_wdata :
                              full_q  ? word_q     : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      rdata_q <= '0;
      full_q  <= 1'b0;
      under_q <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (core_wr) word_q <= core_wdata;
      if (ext_rd)  rdata_q <= read_val;
      if (ext_rd)       full_q <= 1'b0;
      else if (core_wr) full_q <= 1'b1;
      under_q <= under_evt | (under_q & ~clr_sticky);
      err_q   <= under_evt | (err_q   & ~clr_sticky);
      ovr_q   <= ovr_evt   | (ovr_q   & ~clr_sticky);
    end
  end

  assign ext_rdata = rdata_q;
  assign full      = full_q;
  assign underrun  = under_q;
  assign error     = err_q;
  assign overrun   = ovr_q;

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr && !ext_rd |=> full && $past(core_wdata) == word_q); // R1
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd && !core_wr && full |=> !full && ext_rdata == $past(word_q)); // R2
  AST_UNDERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd && !core_wr && !full |=> underrun && error && !full && ext_rdata == '0); // R3
  AST_COLLIDE_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr && ext_rd |=> !full && ext_rdata == $past(core_wdata)); // R4
  AST_COLLIDE_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr && ext_rd && !underrun |=> !underrun); // R4
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rd |=> $stable(ext_rdata)); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_sticky && (underrun || overrun) |=> underrun >= $past(underrun) && overrun >= $past(overrun)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr && full |=> overrun); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_wr && !ext_rd |=> $stable(full) && $stable(word_q)); // R9

endmodule

// File: tb/dbg_tx_channel_test.sv
module dbg_tx_channel_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         core_wr = 1'b0;
  logic [W-1:0] core_wdata = '0;
  logic         ext_rd = 1'b0;
  logic         clr_sticky = 1'b0;
  logic [W-1:0] ext_rdata;
  logic         full, underrun, error, overrun;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  dbg_tx_channel #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .core_wr(core_wr), .core_wdata(core_wdata),
    .ext_rd(ext_rd), .ext_rdata(ext_rdata), .clr_sticky(clr_sticky),
    .full(full), .underrun(underrun), .error(error), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic f, input logic u, input logic e, input logic o);
    chk(req, "full", W'(full), W'(f));
    chk(req, "underrun", W'(underrun), W'(u));
    chk(req, "error", W'(error), W'(e));
    chk(req, "overrun", W'(overrun), W'(o));
  endtask

  // drive at negedge, one posedge, return at next negedge with strobes dropped
  task automatic step(input logic wr, input logic [W-1:0] wd, input logic rd, input logic clr);
    core_wr = wr; core_wdata = wd; ext_rd = rd; clr_sticky = clr;
    @(negedge clk);
    core_wr = 1'b0; ext_rd = 1'b0; clr_sticky = 1'b0;
  endtask

  task automatic t_reset;
    flags("R8", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "rdata", ext_rdata, '0);
  endtask

  task automatic t_write_read;
    step(1'b1, 32'hA5A5_0001, 1'b0, 1'b0);
    flags("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    flags("R9", 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    flags("R2", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2", "rdata", ext_rdata, 32'hA5A5_0001);
    step(1'b0, '0, 1'b0, 1'b0);
    chk("R5", "rdata held", ext_rdata, 32'hA5A5_0001);
  endtask

  task automatic t_underrun;
    step(1'b0, '0, 1'b1, 1'b0);
    flags("R3", 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3", "rdata", ext_rdata, '0);
    step(1'b0, '0, 1'b0, 1'b0);
    flags("R6", 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1);
    flags("R6", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_overrun;
    step(1'b1, 32'h0000_BEEF, 1'b0, 1'b0);
    step(1'b1, 32'hC0DE_0002, 1'b0, 1'b0);
    flags("R7", 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R7", "newest word", ext_rdata, 32'hC0DE_0002);
    flags("R7", 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1);
    flags("R6", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_collide_empty;
    step(1'b1, 32'h1234_5678, 1'b1, 1'b0);
    chk("R4", "rdata", ext_rdata, 32'h1234_5678);
    flags("R4", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_collide_full;
    step(1'b1, 32'h0000_00E1, 1'b0, 1'b0);
    step(1'b1, 32'hFACE_00F2, 1'b1, 1'b0);
    chk("R4", "rdata on full", ext_rdata, 32'hFACE_00F2);
    flags("R4", 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1);
  endtask

  task automatic t_clear_vs_event;
    step(1'b0, '0, 1'b1, 1'b0);
    flags("R3", 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, '0, 1'b1, 1'b1);
    flags("R6", 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1);
    flags("R6", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    fork
      begin
        #20 @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_underrun();
        t_overrun();
        t_collide_empty();
        t_collide_full();
        t_clear_vs_event();
      end
      begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule